// File: doc/BRIEF.md
# LDPC Variable-Node Update with Hard Decision

This block is the per-bit processing element of an iterative LDPC decoder built on belief propagation in the log-likelihood domain. Every cycle it may take one channel log-likelihood value and one incoming message from each of the check nodes attached to this bit. From these it forms one outgoing message per edge and a decoded bit. Each outgoing message is the total belief minus that edge's own incoming contribution. The decoded bit is the sign of the total belief. All messages are short two's complement words that saturate symmetrically.

A seed flag covers the first half-iteration, when no check messages exist yet. While the flag is set, every outgoing message is the channel value and the decoded bit follows the channel sign. A small state machine records what the output registers hold:
- `ST_IDLE`: nothing new.
- `ST_SEED`: seeded messages.
- `ST_EXTR`: extrinsic messages.

On each clock the machine takes one of three transitions:
- `go_seed` when a strobe arrives with the seed flag set.
- `go_extr` when a strobe arrives with the seed flag clear.
- `go_idle` when there is no strobe.

The output-valid flag is high in every state except `ST_IDLE`.

Top module: `ldpc_bitnode`

## Requirements
- R1: While reset (`rst_n` low) is asserted and right after it, `out_valid`, `out_bit` and every bit of `out_msg` are 0.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low after a cycle with `in_valid` low.
- R3: With `in_init` low, outgoing message i is the saturated value of the channel value plus the sum of all incoming check messages, minus incoming check message i.
- R4: Each outgoing message is clamped to the range from -(2^(MSG_W-1)-1) to 2^(MSG_W-1)-1. The most negative code (sign bit set, all other bits zero) never appears on an output.
- R5: With `in_init` low, `out_bit` is 1 when the channel value plus all check messages is negative, and 0 when that total is zero or positive.
- R6: With `in_init` high, every outgoing message is the saturated channel value, and the check messages have no effect on any output.
- R7: With `in_init` high, `out_bit` is 1 when the channel value is negative and 0 otherwise.
- R8: In a cycle with `in_valid` low, `out_msg` and `out_bit` keep their previous values, whatever `ch_llr` and `chk_msg` carry.
- R9: Edge i uses bits [i*MSG_W +: MSG_W] of both `chk_msg` and `out_msg`. Edge 0 is in the least significant slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input strobe |
| in_init | input | 1 | Seed flag: the channel value is sent on every edge |
| ch_llr | input | MSG_W | Channel log-likelihood, two's complement |
| chk_msg | input | DEG*MSG_W | Incoming check messages, one slot per edge |
| out_valid | output | 1 | Outputs updated in the previous cycle |
| out_msg | output | DEG*MSG_W | Outgoing messages, one slot per edge |
| out_bit | output | 1 | Hard decision (1 means negative belief) |

## Verification
The properties assume that incoming check messages never carry the most negative code, because an upstream node that obeys the same saturation rule cannot produce it. The channel value may take any code, including the most negative one.

The stimulus draws check messages uniformly from the symmetric range. It uses the most negative code only for the channel, including one directed seed case that must clamp.

Between strobes the bench also drives fresh random data with the strobe low, so the hold behaviour is exercised.

// File: rtl/bn_pkg.sv
package bn_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEED = 2'd1,
        ST_EXTR = 2'd2
    } bn_state_t;

    // total of channel plus DEG messages needs this many bits
    function automatic int sum_width(input int msg_w, input int deg);
        return msg_w + $clog2(deg + 1);
    endfunction
endpackage

// File: rtl/bn_total.sv
module bn_total #(
    parameter int DEG   = 5,
    parameter int MSG_W = 4,
    parameter int SUM_W = 7
) (
    input  logic signed [MSG_W-1:0]     ch,
    input  logic        [DEG*MSG_W-1:0] chk_bus,
    output logic signed [SUM_W-1:0]     total
);
    logic signed [MSG_W-1:0] slot [DEG];

    for (genvar g = 0; g < DEG; g++) begin : g_slot
        assign slot[g] = chk_bus[g*MSG_W +: MSG_W];
    end

    always_comb begin
        total = SUM_W'(ch);
        for (int i = 0; i < DEG; i++) begin
            total = total + SUM_W'(slot[i]);
        end
    end
endmodule

// File: rtl/bn_edge.sv
module bn_edge #(
    parameter int MSG_W = 4,
    parameter int SUM_W = 7
) (
    input  logic                    seed,
    input  logic signed [SUM_W-1:0] total,
    input  logic signed [MSG_W-1:0] own,
    input  logic signed [MSG_W-1:0] ch,
    output logic signed [MSG_W-1:0] msg_out
);
    localparam logic signed [SUM_W-1:0] LIM_P = SUM_W'((1 << (MSG_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] LIM_N = -LIM_P;

    logic signed [SUM_W-1:0] src;

    always_comb begin
        src = seed ? SUM_W'(ch) : (total - SUM_W'(own));
        if (src > LIM_P) begin
            msg_out = LIM_P[MSG_W-1:0];
        end else if (src < LIM_N) begin
            msg_out = LIM_N[MSG_W-1:0];
        end else begin
            msg_out = src[MSG_W-1:0];
        end
    end
endmodule

// File: rtl/ldpc_bitnode.sv
module ldpc_bitnode
    import bn_pkg::*;
#(
    parameter int DEG   = 5,
    parameter int MSG_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_init,
    input  logic [MSG_W-1:0]     ch_llr,
    input  logic [DEG*MSG_W-1:0] chk_msg,
    output logic                 out_valid,
    output logic [DEG*MSG_W-1:0] out_msg,
    output logic                 out_bit
);
    localparam int SUM_W = sum_width(MSG_W, DEG);

    bn_state_t state_q, state_d;

    logic signed [SUM_W-1:0] total;
    logic signed [MSG_W-1:0] ch_s;
    logic [DEG*MSG_W-1:0]    msg_d;
    logic                    bit_d;

    assign ch_s = ch_llr;

    bn_total #(.DEG(DEG), .MSG_W(MSG_W), .SUM_W(SUM_W)) u_total (
        .ch      (ch_s),
        .chk_bus (chk_msg),
        .total   (total)
    );

    for (genvar e = 0; e < DEG; e++) begin : g_edge
        bn_edge #(.MSG_W(MSG_W), .SUM_W(SUM_W)) u_edge (
            .seed    (in_init),
            .total   (total),
            .own     (chk_msg[e*MSG_W +: MSG_W]),
            .ch      (ch_s),
            .msg_out (msg_d[e*MSG_W +: MSG_W])
        );
    end

    assign bit_d = in_init ? ch_s[MSG_W-1] : total[SUM_W-1];

    // next-state logic: go_seed / go_extr / go_idle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_SEED, ST_EXTR: begin
                if (in_valid) state_d = in_init ? ST_SEED : ST_EXTR;
                else          state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_msg <= '0;
            out_bit <= 1'b0;
        end else if (in_valid) begin
            out_msg <= msg_d;
            out_bit <= bit_d;
        end
    end

    assign out_valid = (state_q != ST_IDLE);
endmodule

// File: rtl/bn_check.sv
module bn_check #(
    parameter int DEG   = 5,
    parameter int MSG_W = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_init,
    input logic [MSG_W-1:0]     ch_llr,
    input logic [DEG*MSG_W-1:0] chk_msg,
    input logic                 out_valid,
    input logic [DEG*MSG_W-1:0] out_msg,
    input logic                 out_bit
);
    localparam logic [MSG_W-1:0] MIN_CODE = {1'b1, {(MSG_W-1){1'b0}}};

    function automatic logic has_min(input logic [DEG*MSG_W-1:0] b);
        logic f;
        f = 1'b0;
        for (int i = 0; i < DEG; i++) begin
            if (b[i*MSG_W +: MSG_W] == MIN_CODE) f = 1'b1;
        end
        return f;
    endfunction

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_NO_MIN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !has_min(out_msg)); // R4
    AST_SEED_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_init && ch_llr != MIN_CODE) |=> out_msg == {DEG{$past(ch_llr)}}); // R6
    AST_SEED_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_init) |=> out_bit == $past(ch_llr[MSG_W-1])); // R7
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_msg) && $stable(out_bit))); // R8
endmodule

bind ldpc_bitnode bn_check #(.DEG(DEG), .MSG_W(MSG_W)) u_bn_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_init   (in_init),
    .ch_llr    (ch_llr),
    .chk_msg   (chk_msg),
    .out_valid (out_valid),
    .out_msg   (out_msg),
    .out_bit   (out_bit)
);

// File: tb/test_ldpc_bitnode.sv
`timescale 1ns/1ps
module test_ldpc_bitnode;
    localparam int DEG   = 5;
    localparam int MSG_W = 4;
    localparam int LIM   = (1 << (MSG_W - 1)) - 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic                 in_init = 1'b0;
    logic [MSG_W-1:0]     ch_llr = '0;
    logic [DEG*MSG_W-1:0] chk_msg = '0;
    logic                 out_valid;
    logic [DEG*MSG_W-1:0] out_msg;
    logic                 out_bit;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ldpc_bitnode #(.DEG(DEG), .MSG_W(MSG_W)) i_ldpc_bitnode (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_init(in_init),
        .ch_llr(ch_llr), .chk_msg(chk_msg), .out_valid(out_valid),
        .out_msg(out_msg), .out_bit(out_bit)
    );

    function automatic int sat(input int v);
        if (v > LIM)  return LIM;
        if (v < -LIM) return -LIM;
        return v;
    endfunction

    function automatic int slot_of(input logic [DEG*MSG_W-1:0] b, input int i);
        logic signed [MSG_W-1:0] s;
        s = b[i*MSG_W +: MSG_W];
        return int'(s);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply(input bit init, input int ch, input int m [DEG]);
        int total;
        logic [DEG*MSG_W-1:0] held;
        logic held_bit;
        total = ch;
        @(negedge clk);
        in_valid = 1'b1;
        in_init  = init;
        ch_llr   = MSG_W'(ch);
        for (int i = 0; i < DEG; i++) begin
            chk_msg[i*MSG_W +: MSG_W] = MSG_W'(m[i]);
            total += m[i];
        end
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R2", int'(out_valid), 1);
        for (int i = 0; i < DEG; i++) begin
            if (init)
                check(slot_of(out_msg, i) == sat(ch), "R6", slot_of(out_msg, i), sat(ch));
            else
                check(slot_of(out_msg, i) == sat(total - m[i]), "R3", slot_of(out_msg, i), sat(total - m[i]));
        end
        if (init) check(out_bit == (ch < 0), "R7", int'(out_bit), int'(ch < 0));
        else      check(out_bit == (total < 0), "R5", int'(out_bit), int'(total < 0));
        held = out_msg;
        held_bit = out_bit;
        // fresh data with strobe low must not disturb outputs
        ch_llr  = MSG_W'($urandom);
        chk_msg = (DEG*MSG_W)'({$urandom, $urandom});
        in_init = 1'($urandom);
        @(negedge clk);
        check(out_valid == 1'b0, "R2", int'(out_valid), 0);
        check(out_msg == held, "R8", int'(out_msg), int'(held));
        check(out_bit == held_bit, "R8", int'(out_bit), int'(held_bit));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int m [DEG];
        int lo;
        void'($urandom(32'd20417));
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", int'(out_valid), 0);
        check(out_bit == 1'b0, "R1", int'(out_bit), 0);
        check(out_msg == '0, "R1", int'(out_msg), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && out_msg == '0, "R1", int'(out_valid), 0);

        // R5: zero total decides 0
        m = '{0, 0, 0, 0, 0};
        apply(1'b0, 0, m);
        // R9: distinct per-slot values with zero total
        m = '{1, -1, 2, -2, 0};
        apply(1'b0, 0, m);
        n_run++;
        if (slot_of(out_msg, 0) != -1 || slot_of(out_msg, 3) != 2) begin
            n_fail++;
            $display("FAIL R9: actual %0d expected %0d", slot_of(out_msg, 0), -1);
        end
        // R4: positive and negative clamp
        m = '{LIM, LIM, LIM, LIM, LIM};
        apply(1'b0, LIM, m);
        m = '{-LIM, -LIM, -LIM, -LIM, -LIM};
        apply(1'b0, -LIM - 1, m);
        // R6/R7: seed ignores check messages
        m = '{-LIM, -LIM, -LIM, -LIM, -LIM};
        apply(1'b1, 3, m);
        apply(1'b1, -5, m);
        // R4: seed with most negative channel code clamps
        apply(1'b1, -LIM - 1, m);
        lo = slot_of(out_msg, 2);
        check(lo == -LIM, "R4", lo, -LIM);

        for (int k = 0; k < 300; k++) begin
            for (int i = 0; i < DEG; i++) m[i] = int'($urandom % (2 * LIM + 1)) - LIM;
            apply(($urandom % 5) == 0, int'($urandom % (2 * LIM + 2)) - LIM - 1, m);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule